// File: doc/BRIEF.md
# Addressed DAC Serial Frame Transmitter

This block is a host-side serial master that updates one channel of an eight-channel, 8-bit digital-to-analog converter. The user presents a 3-bit channel number and an 8-bit value and pulses a start strobe. The block then pulls the active-low chip select down, shifts the address and the value out most significant bit first on a data line, and toggles a serial clock that rests high. Finally it raises chip select, which makes the addressed converter channel take the new value. A one-cycle done pulse follows.

A mode input picks the frame layout. The compact layout is 11 bits long: the three address bits come first, followed directly by the eight value bits. The byte layout is 16 bits long: an address byte that holds the channel number in its three low bits, with zeros above it, and then the value byte. A second input lets the user hand the value over in reversed bit order, and the block flips it back before sending. The serial clock is the system clock divided by an even parameter, with equal low and high phases. Two static active-low outputs, converter shutdown and converter reset, are held inactive (high).

The controller is a six-state machine:
- IDLE waits for start.
- LEAD holds chip select low with the clock high for one phase.
- LOW drives a bit while the clock is low.
- HIGH holds the clock high. From HIGH the machine goes back to LOW while bits remain, and to CLOSE after the last bit.
- CLOSE keeps chip select high for one phase.
- DONE lasts one cycle and then returns to IDLE.

Top module: `dac_frame_tx`

## Requirements
- R1: After reset, and in idle, cs_n_o and sclk_o are 1, and busy_o and done_o are 0.
- R2: A start_i pulse that is accepted while busy_o is 0 drives cs_n_o low and busy_o high in the next cycle. sclk_o stays 1 at the moment cs_n_o falls.
- R3: With byte_mode_i = 0 the frame has exactly 11 rising clock edges. It carries chan_i[2] down to chan_i[0], then the value from bit 7 down to bit 0.
- R4: With byte_mode_i = 1 the frame has exactly 16 rising clock edges. It carries five 0 bits, then chan_i[2:0], then the value from bit 7 down to bit 0.
- R5: sclk_o is 0 only while cs_n_o is 0. sdo_o does not change while sclk_o is high inside a frame.
- R6: Every low phase of sclk_o lasts SCLK_DIV/2 system clocks.
- R7: cs_n_o returns high after the last rising clock edge. done_o then pulses for exactly one cycle while cs_n_o is high, after which busy_o is 0.
- R8: A start_i pulse that arrives while busy_o is 1 is ignored. The frame in progress is unchanged, and no further frame follows.
- R9: With lsb_first_i = 1 the value is taken as bit-reversed: value_i[0] is sent first among the value bits. The address bits are not affected.
- R10: shdn_n_o and dac_rst_n_o are 1 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start strobe, one cycle |
| chan_i | input | 3 | Channel address |
| value_i | input | 8 | Value to write |
| byte_mode_i | input | 1 | 0 = 11-bit frame, 1 = 16-bit frame |
| lsb_first_i | input | 1 | 1 = value_i is supplied bit-reversed |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-cycle completion pulse |
| cs_n_o | output | 1 | Active-low chip select |
| sclk_o | output | 1 | Serial clock, idles high |
| sdo_o | output | 1 | Serial data, MSB first |
| shdn_n_o | output | 1 | Active-low shutdown, held high |
| dac_rst_n_o | output | 1 | Active-low converter reset, held high |

## Verification
The bench goes after the following corner cases, each with the failure it would catch:
- Frame length in both modes. An off-by-one bit counter would emit 10, 12, 15 or 17 edges.
- Byte-mode padding. Address bits placed in the wrong part of the byte would corrupt the captured word.
- Reversal applied to the address as well as the value. This would scramble the channel number.
- A start strobe injected mid-frame with different inputs. A design that re-latches would either corrupt the word or launch an extra frame.
- Per-edge monitoring of the serial waveform. This catches data that changes during the high phase and low phases of the wrong length.

// File: rtl/dac_frame_pkg.sv
package dac_frame_pkg;
    localparam int ADDR_W    = 3;
    localparam int DATA_W    = 8;
    localparam int BYTE_W    = 8;
    localparam int FRAME_W   = 2 * BYTE_W;
    localparam int SHORT_LEN = ADDR_W + DATA_W;
    localparam int CNT_W     = $clog2(FRAME_W + 1);

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LEAD,
        ST_LOW,
        ST_HIGH,
        ST_CLOSE,
        ST_DONE
    } tx_state_e;
endpackage

// File: rtl/dac_phase_timer.sv
module dac_phase_timer #(
    parameter int HALF = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    output logic tick_o
);
    localparam int CW = (HALF > 1) ? $clog2(HALF) : 1;
    localparam logic [CW-1:0] LAST = CW'(HALF - 1);

    logic [CW-1:0] cnt_q;

    assign tick_o = run_i && (cnt_q == LAST);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= '0;
        else if (!run_i || tick_o)
            cnt_q <= '0;
        else
            cnt_q <= cnt_q + 1'b1;
    end
endmodule

// File: rtl/dac_bit_rev.sv
module dac_bit_rev #(
    parameter int W = 8
) (
    input  logic [W-1:0] in_i,
    output logic [W-1:0] out_o
);
    for (genvar i = 0; i < W; i++) begin : g_rev
        assign out_o[i] = in_i[W-1-i];
    end
endmodule

// File: rtl/dac_frame_pack.sv
module dac_frame_pack
    import dac_frame_pkg::*;
(
    input  logic [ADDR_W-1:0]  chan_i,
    input  logic [DATA_W-1:0]  value_i,
    input  logic               byte_mode_i,
    output logic [FRAME_W-1:0] word_o,
    output logic [CNT_W-1:0]   len_o
);
    localparam int PAD_TAIL = FRAME_W - SHORT_LEN;
    localparam int PAD_ADDR = BYTE_W - ADDR_W;

    always_comb begin
        if (byte_mode_i) begin
            word_o = {{PAD_ADDR{1'b0}}, chan_i, value_i};
            len_o  = CNT_W'(FRAME_W);
        end else begin
            word_o = {chan_i, value_i, {PAD_TAIL{1'b0}}};
            len_o  = CNT_W'(SHORT_LEN);
        end
    end
endmodule

// File: rtl/dac_frame_tx.sv
module dac_frame_tx
    import dac_frame_pkg::*;
#(
    parameter int SCLK_DIV = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] chan_i,
    input  logic [DATA_W-1:0] value_i,
    input  logic              byte_mode_i,
    input  logic              lsb_first_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              cs_n_o,
    output logic              sclk_o,
    output logic              sdo_o,
    output logic              shdn_n_o,
    output logic              dac_rst_n_o
);
    localparam int HALF = (SCLK_DIV / 2 < 1) ? 1 : SCLK_DIV / 2;

    tx_state_e state_q, state_d;
    logic [FRAME_W-1:0] shreg_q;
    logic [CNT_W-1:0]   left_q;
    logic [DATA_W-1:0]  val_rev, val_sel;
    logic [FRAME_W-1:0] pack_word;
    logic [CNT_W-1:0]   pack_len;
    logic               tick, run, accept, last_bit;

    dac_bit_rev #(.W(DATA_W)) u_rev (
        .in_i  (value_i),
        .out_o (val_rev)
    );

    assign val_sel = lsb_first_i ? val_rev : value_i;

    dac_frame_pack u_pack (
        .chan_i      (chan_i),
        .value_i     (val_sel),
        .byte_mode_i (byte_mode_i),
        .word_o      (pack_word),
        .len_o       (pack_len)
    );

    assign run = (state_q != ST_IDLE) && (state_q != ST_DONE);

    dac_phase_timer #(.HALF(HALF)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .tick_o (tick)
    );

    assign accept   = (state_q == ST_IDLE) && start_i;
    assign last_bit = (left_q == CNT_W'(1));

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:  if (start_i) state_d = ST_LEAD;
            ST_LEAD:  if (tick) state_d = ST_LOW;
            ST_LOW:   if (tick) state_d = ST_HIGH;
            ST_HIGH:  if (tick) state_d = last_bit ? ST_CLOSE : ST_LOW;
            ST_CLOSE: if (tick) state_d = ST_DONE;
            ST_DONE:  state_d = ST_IDLE;
            default:  state_d = ST_IDLE;
        endcase
    end

    // state register and shift datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            shreg_q <= '0;
            left_q  <= '0;
        end else begin
            state_q <= state_d;
            if (accept) begin
                shreg_q <= pack_word;
                left_q  <= pack_len;
            end else if (state_q == ST_HIGH && tick && !last_bit) begin
                shreg_q <= {shreg_q[FRAME_W-2:0], 1'b0};
                left_q  <= left_q - 1'b1;
            end
        end
    end

    // output decode
    always_comb begin
        cs_n_o = 1'b1;
        sclk_o = 1'b1;
        sdo_o  = 1'b0;
        busy_o = 1'b1;
        done_o = 1'b0;
        unique case (state_q)
            ST_IDLE:  busy_o = 1'b0;
            ST_LEAD: begin
                cs_n_o = 1'b0;
                sdo_o  = shreg_q[FRAME_W-1];
            end
            ST_LOW: begin
                cs_n_o = 1'b0;
                sclk_o = 1'b0;
                sdo_o  = shreg_q[FRAME_W-1];
            end
            ST_HIGH: begin
                cs_n_o = 1'b0;
                sdo_o  = shreg_q[FRAME_W-1];
            end
            ST_CLOSE: ;
            ST_DONE:  done_o = 1'b1;
            default:  busy_o = 1'b0;
        endcase
    end

    assign shdn_n_o    = 1'b1;
    assign dac_rst_n_o = 1'b1;
endmodule

// File: rtl/dac_frame_tx_chk.sv
module dac_frame_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic start_i,
    input logic byte_mode_i,
    input logic busy_o,
    input logic done_o,
    input logic cs_n_o,
    input logic sclk_o,
    input logic sdo_o
);
    logic       mode_q;
    logic       sclk_prev;
    logic [4:0] edges_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mode_q    <= 1'b0;
            sclk_prev <= 1'b1;
            edges_q   <= '0;
        end else begin
            sclk_prev <= sclk_o;
            if (start_i && !busy_o) begin
                mode_q  <= byte_mode_i;
                edges_q <= '0;
            end else if (!cs_n_o && sclk_o && !sclk_prev) begin
                edges_q <= edges_q + 1'b1;
            end
        end
    end

    // R2
    cs_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n_o) |-> ($past(start_i) && !$past(busy_o) && sclk_o));

    // R3 R4
    frame_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n_o) |-> (edges_q == (mode_q ? 5'd16 : 5'd11)));

    // R5
    clk_in_frame_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_o |-> !cs_n_o);

    // R5
    sdo_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_o && $past(sclk_o) && !cs_n_o && !$past(cs_n_o)) |-> $stable(sdo_o));

    // R7
    done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    // R7
    done_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (cs_n_o && $past(cs_n_o)));
endmodule

bind dac_frame_tx dac_frame_tx_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start_i     (start_i),
    .byte_mode_i (byte_mode_i),
    .busy_o      (busy_o),
    .done_o      (done_o),
    .cs_n_o      (cs_n_o),
    .sclk_o      (sclk_o),
    .sdo_o       (sdo_o)
);

// File: tb/dac_frame_tx_tb.sv
`timescale 1ns/1ps
module dac_frame_tx_tb;
    localparam int DIV  = 4;
    localparam int HALF = DIV / 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] chan_i = '0;
    logic [7:0] value_i = '0;
    logic byte_mode_i = 1'b0;
    logic lsb_first_i = 1'b0;
    logic busy_o, done_o, cs_n_o, sclk_o, sdo_o, shdn_n_o, dac_rst_n_o;

    int total = 0;
    int failed = 0;

    always #2 clk = ~clk;

    dac_frame_tx #(.SCLK_DIV(DIV)) u_dut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .chan_i(chan_i),
        .value_i(value_i), .byte_mode_i(byte_mode_i), .lsb_first_i(lsb_first_i),
        .busy_o(busy_o), .done_o(done_o), .cs_n_o(cs_n_o), .sclk_o(sclk_o),
        .sdo_o(sdo_o), .shdn_n_o(shdn_n_o), .dac_rst_n_o(dac_rst_n_o)
    );

    // waveform monitor
    logic [15:0] cap = '0;
    int ncap = 0, frames = 0;
    int lowrun = 0;
    int lead_err = 0, stab_err = 0, phase_err = 0, done_err = 0, static_err = 0;
    logic p_sclk = 1'b1, p_cs = 1'b1, p_sdo = 1'b0, p_done = 1'b0;

    always @(negedge clk) begin
        if (rst_n) begin
            if (p_cs && !cs_n_o) begin
                frames++;
                cap = '0;
                ncap = 0;
                if (!sclk_o) lead_err++;
            end
            if (!cs_n_o && sclk_o && !p_sclk) begin
                cap = {cap[14:0], sdo_o};
                ncap++;
            end
            if (!sclk_o && cs_n_o) stab_err++;
            if (sclk_o && p_sclk && !cs_n_o && !p_cs && sdo_o != p_sdo) stab_err++;
            if (!sclk_o) lowrun++;
            if (sclk_o && !p_sclk) begin
                if (lowrun != HALF) phase_err++;
                lowrun = 0;
            end
            if (done_o && (!cs_n_o || p_done)) done_err++;
            if (!shdn_n_o || !dac_rst_n_o) static_err++;
            p_sclk = sclk_o;
            p_cs = cs_n_o;
            p_sdo = sdo_o;
            p_done = done_o;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        total++;
        if (!ok) begin
            failed++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] rev8(input logic [7:0] v);
        for (int i = 0; i < 8; i++) rev8[i] = v[7-i];
    endfunction

    function automatic logic [15:0] exp_word(input logic [2:0] ch, input logic [7:0] v,
                                             input bit lsbf);
        exp_word = {5'b0, ch, (lsbf ? rev8(v) : v)};
    endfunction

    task automatic xfer(input logic [2:0] ch, input logic [7:0] v, input bit mode,
                        input bit lsbf, input bit inject);
        int f0, waitc;
        @(negedge clk);
        chan_i = ch; value_i = v; byte_mode_i = mode; lsb_first_i = lsbf; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        check(!cs_n_o && busy_o, "R2 frame open", {cs_n_o, busy_o}, 2'b01);
        if (inject) begin
            repeat (10) @(negedge clk);
            chan_i = ~ch; value_i = ~v; byte_mode_i = ~mode; start_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0;
        end
        waitc = 0;
        while (!done_o && waitc < 2000) begin
            @(negedge clk);
            waitc++;
        end
        check(done_o && cs_n_o, "R7 done with cs high", {done_o, cs_n_o}, 2'b11);
        check(ncap == (mode ? 16 : 11), mode ? "R4 bit count" : "R3 bit count",
              ncap, mode ? 16 : 11);
        check(cap == exp_word(ch, v, lsbf),
              lsbf ? "R9 reversed value" : (mode ? "R4 frame word" : "R3 frame word"),
              cap, exp_word(ch, v, lsbf));
        f0 = frames;
        @(negedge clk);
        check(!done_o && !busy_o, "R7 done one cycle then idle", {done_o, busy_o}, 0);
        if (inject) begin
            repeat (20) @(negedge clk);
            check(frames == f0 && cs_n_o && !busy_o, "R8 no extra frame", frames, f0);
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        failed++;
        total++;
        $display("FAIL watchdog expired actual=timeout expected=finish");
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end

    initial begin
        int unsigned seed;
        seed = $urandom(32'd4242);
        repeat (3) @(negedge clk);
        check(cs_n_o && sclk_o && !busy_o && !done_o, "R1 reset state",
              {cs_n_o, sclk_o, busy_o, done_o}, 4'b1100);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(cs_n_o && sclk_o && !busy_o && !done_o, "R1 idle state",
              {cs_n_o, sclk_o, busy_o, done_o}, 4'b1100);
        check(shdn_n_o && dac_rst_n_o, "R10 static lines", {shdn_n_o, dac_rst_n_o}, 2'b11);
        // directed corners
        xfer(3'b111, 8'hFF, 1'b0, 1'b0, 1'b0);
        xfer(3'b000, 8'h00, 1'b1, 1'b0, 1'b0);
        xfer(3'b101, 8'h01, 1'b0, 1'b1, 1'b0);
        xfer(3'b111, 8'h80, 1'b1, 1'b1, 1'b0);
        xfer(3'b010, 8'hA5, 1'b0, 1'b0, 1'b1);
        xfer(3'b110, 8'h3C, 1'b1, 1'b0, 1'b1);
        // constrained random
        for (int n = 0; n < 40; n++) begin
            xfer(3'($urandom), 8'($urandom), 1'($urandom), 1'($urandom),
                 ($urandom % 5) == 0);
        end
        check(lead_err == 0, "R2 clock high at cs fall", lead_err, 0);
        check(stab_err == 0, "R5 data stable high phase", stab_err, 0);
        check(phase_err == 0, "R6 low phase length", phase_err, 0);
        check(done_err == 0, "R7 done pulse shape", done_err, 0);
        check(static_err == 0, "R10 static lines held", static_err, 0);
        $display("%0d/%0d checks passed", total - failed, total);
        $finish;
    end
endmodule